// File: doc/BRIEF.md
# I2C Bus-Busy Monitor

This block watches the two wires of an I2C bus from the side and reports whether a transfer is in progress. It brings SCL and SDA into the system clock domain, recognises the bus framing events (the opening START and the closing STOP), and keeps a busy flag that rises with the first and falls with the second. Each recognised event is also announced as a one-clock pulse, so a controller can wait for the bus to be free before it opens a transfer.

The block has a module-level enable, `run_en`, that acts as a soft reset. While it is low, nothing on the bus is recognised and the flag is forced clear. After it goes high, the flag keeps its cleared value and does not guess at the bus from the static wire levels. It waits for a real event instead. A separate `busy_valid` output tells the user when that first event has been seen, which is when `busy` can be trusted.

Top module: `i2c_busy_monitor`

## Requirements
- R1: A START (SDA going 1 to 0 while SCL is 1 in both the old and the new synchronized sample) sets `busy` to 1 and raises `start_pulse`.
- R2: A STOP (SDA going 0 to 1 while SCL is 1 in both the old and the new synchronized sample) clears `busy` to 0 and raises `stop_pulse`.
- R3: While `run_en` is 0, neither `start_pulse` nor `stop_pulse` is raised, whatever the bus does.
- R4: While `run_en` is 0, `busy` and `busy_valid` read 0 from the clock edge after `run_en` is sampled low.
- R5: After `run_en` rises, `busy` stays 0 until the first START or STOP, even when the lines rest at a mid-transfer level (SCL 1, SDA 0).
- R6: A START seen while `busy` is already 1 (a repeated START) keeps `busy` at 1 and still raises `start_pulse`.
- R7: An SDA change while SCL is 0, or an SDA change in the same synchronized sample as an SCL change, is not a START or STOP and leaves `busy` unchanged.
- R8: `busy_valid` rises together with the first START or STOP pulse after `run_en` is high. It then stays 1 until `run_en` goes low or `rst_n` is asserted.
- R9: A line change driven between clock edges shows on the pulse output after the third rising edge. Each pulse lasts exactly one clock cycle.
- R10: An event whose detection falls in the first cycle that `run_en` is sampled high is counted. An event detected one cycle before that is lost.
- R11: While `rst_n` is 0, `busy`, `busy_valid` and both pulses are 0, and the synchronizer reads the bus as idle (both lines 1).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| run_en | input | 1 | Module enable. When low, the block is held in soft reset |
| scl_in | input | 1 | Raw SCL line level |
| sda_in | input | 1 | Raw SDA line level |
| busy | output | 1 | Bus-busy flag |
| busy_valid | output | 1 | A condition has been seen since enable, so `busy` can be trusted |
| start_pulse | output | 1 | One-cycle pulse per START detected |
| stop_pulse | output | 1 | One-cycle pulse per STOP detected |

## Verification
The enable release and the recognition of a bus event can land in the same clock cycle. The bench provokes this by dropping SDA while the block is disabled and raising `run_en` exactly in the cycle where the synchronized edge is judged. It expects the START to be counted and the flag and validity to rise. Moving the release one cycle later must lose the event. A second collision, SCL and SDA changing in one cycle, is driven both directed and inside random walks of the lines, and the bench expects no event from it.

// File: rtl/i2cbm_pkg.sv
// Package: shared types for the bus-busy monitor.
// Holds the sampled line pair so that every stage handles SCL and SDA together.
package i2cbm_pkg;

    // One sample of the two bus wires
    typedef struct packed {
        logic scl;
        logic sda;
    } i2cbm_lines_t;

    localparam int LINES_W = $bits(i2cbm_lines_t);

endpackage

// File: rtl/i2cbm_sync.sv
// Module: i2cbm_sync
// Multi-stage flop chain that brings asynchronous bus wires into the clk domain.
// Assumes the idle bus level is all ones, so reset presets every stage high.
module i2cbm_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        logic [WIDTH-1:0] stage_in;

        if (i == 0) begin : g_first
            assign stage_in = d;
        end else begin : g_next
            assign stage_in = stage_q[i-1];
        end

        // Shift one stage per clock and preset to idle-high on reset
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stage_q[i] <= '1;
            end else begin
                stage_q[i] <= stage_in;
            end
        end
    end

    assign q = stage_q[STAGES-1];

endmodule

// File: rtl/i2cbm_cond_detect.sv
// Module: i2cbm_cond_detect
// Compares each synchronized line sample with the one before it and flags
// START and STOP events. Assumes the input is already in the clk domain.
// SCL must be high in both samples, so an SDA change that coincides with an
// SCL change is not treated as an event.
module i2cbm_cond_detect
    import i2cbm_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  i2cbm_lines_t cur,
    output logic         start_hit,
    output logic         stop_hit
);

    i2cbm_lines_t prev_q;
    logic         scl_held_high;

    // Keep the previous sample. It follows the lines even while disabled
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '{scl: 1'b1, sda: 1'b1};
        end else begin
            prev_q <= cur;
        end
    end

    // Recognise SDA edges that happen while SCL stays high
    always_comb begin
        scl_held_high = prev_q.scl & cur.scl;
        start_hit     = scl_held_high &  prev_q.sda & ~cur.sda;
        stop_hit      = scl_held_high & ~prev_q.sda &  cur.sda;
    end

endmodule

// File: rtl/i2cbm_flag.sv
// Module: i2cbm_flag
// Holds the busy and validity state and registers the one-cycle event pulses.
// Assumes start_hit and stop_hit are never high together. run_en low acts as
// a soft reset: state is cleared and events are dropped.
module i2cbm_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic run_en,
    input  logic start_hit,
    input  logic stop_hit,
    output logic busy,
    output logic busy_valid,
    output logic start_pulse,
    output logic stop_pulse
);

    // Register the pulses and update the flag and its validity
    always_ff @(posedge clk) begin
        if (!rst_n || !run_en) begin
            busy        <= 1'b0;
            busy_valid  <= 1'b0;
            start_pulse <= 1'b0;
            stop_pulse  <= 1'b0;
        end else begin
            start_pulse <= start_hit;
            stop_pulse  <= stop_hit;
            if (start_hit) begin
                busy <= 1'b1;
            end else if (stop_hit) begin
                busy <= 1'b0;
            end
            if (start_hit || stop_hit) begin
                busy_valid <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/i2c_busy_monitor.sv
// Module: i2c_busy_monitor
// Top level of the bus-busy monitor. It synchronizes SCL and SDA, detects START
// and STOP, and keeps the busy flag with its validity indicator.
// Assumes the raw lines are asynchronous to clk and idle high.
module i2c_busy_monitor
    import i2cbm_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_en,
    input  logic scl_in,
    input  logic sda_in,
    output logic busy,
    output logic busy_valid,
    output logic start_pulse,
    output logic stop_pulse
);

    i2cbm_lines_t raw_lines;
    i2cbm_lines_t sync_lines;
    logic         start_hit;
    logic         stop_hit;

    // Pack the raw wires into the shared line type
    always_comb begin
        raw_lines.scl = scl_in;
        raw_lines.sda = sda_in;
    end

    i2cbm_sync #(
        .STAGES (SYNC_STAGES),
        .WIDTH  (LINES_W)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_lines),
        .q     (sync_lines)
    );

    i2cbm_cond_detect u_detect (
        .clk       (clk),
        .rst_n     (rst_n),
        .cur       (sync_lines),
        .start_hit (start_hit),
        .stop_hit  (stop_hit)
    );

    i2cbm_flag u_flag (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_en      (run_en),
        .start_hit   (start_hit),
        .stop_hit    (stop_hit),
        .busy        (busy),
        .busy_valid  (busy_valid),
        .start_pulse (start_pulse),
        .stop_pulse  (stop_pulse)
    );

endmodule

// File: rtl/i2c_busy_monitor_chk.sv
// Module: i2c_busy_monitor_chk
// Checker holding the temporal properties of the monitor, bound to the top.
module i2c_busy_monitor_chk (
    input logic clk,
    input logic rst_n,
    input logic run_en,
    input logic busy,
    input logic busy_valid,
    input logic start_pulse,
    input logic stop_pulse
);

    // R1: a start pulse comes with the flag set
    p_start_sets_r1: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |-> busy);

    // R2: a stop pulse comes with the flag clear
    p_stop_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        stop_pulse |-> !busy);

    // R3: no pulses while the module is disabled
    p_quiet_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> !start_pulse && !stop_pulse);

    // R4: flag and validity cleared while disabled
    p_clear_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> !busy && !busy_valid);

    // R5: the flag only moves with a pulse while enabled
    p_flag_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        run_en && !start_pulse && !stop_pulse && $past(run_en) |-> busy == $past(busy));

    // R8: validity covers every set flag and every pulse
    p_valid_cover_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy || start_pulse || stop_pulse |-> busy_valid);

    // R8: validity never drops while enabled
    p_valid_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy_valid && run_en |=> busy_valid);

    // R9: each pulse is exactly one cycle wide
    p_pulse_width_r9: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse || stop_pulse |=> !start_pulse && !stop_pulse);

    // R11: outputs idle during reset
    always @(posedge clk) begin
        if (!rst_n && $past(!rst_n)) begin
            p_reset_idle_r11: assert (!busy && !busy_valid && !start_pulse && !stop_pulse);
        end
    end

endmodule

bind i2c_busy_monitor i2c_busy_monitor_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .run_en      (run_en),
    .busy        (busy),
    .busy_valid  (busy_valid),
    .start_pulse (start_pulse),
    .stop_pulse  (stop_pulse)
);

// File: tb/i2c_busy_monitor_tb.sv
`timescale 1ns/1ps
module i2c_busy_monitor_tb;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic run_en = 1'b0;
    logic scl_in = 1'b1;
    logic sda_in = 1'b1;
    logic busy, busy_valid, start_pulse, stop_pulse;

    int n_checks = 0;
    int n_fail   = 0;
    int n_start  = 0;
    int n_stop   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    i2c_busy_monitor u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_en      (run_en),
        .scl_in      (scl_in),
        .sda_in      (sda_in),
        .busy        (busy),
        .busy_valid  (busy_valid),
        .start_pulse (start_pulse),
        .stop_pulse  (stop_pulse)
    );

    // Count pulses away from the active edge
    always @(negedge clk) begin
        if (start_pulse) n_start++;
        if (stop_pulse)  n_stop++;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Expected event from one line step, computed from R1/R2/R7
    function automatic int exp_event(input bit ps, input bit pd, input bit ns, input bit nd);
        if (ps && ns && pd && !nd) return 1;
        if (ps && ns && !pd && nd) return 2;
        return 0;
    endfunction

    function automatic int pack3(input bit b, input bit v, input int dummy);
        return dummy * 4 + (b ? 2 : 0) + (v ? 1 : 0);
    endfunction

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        int s0, p0;
        bit es, ed, eb, ev, en;
        void'($urandom(32'h1D2C));

        // R11: reset state
        cyc(4);
        check(!busy && !busy_valid && !start_pulse && !stop_pulse, "R11", "reset outputs",
              pack3(busy, busy_valid, 0), 0);
        rst_n = 1'b1;
        cyc(3);

        // R5: enable with idle bus leaves the flag clear
        run_en = 1'b1;
        cyc(6);
        check(!busy && !busy_valid, "R5", "idle after enable", pack3(busy, busy_valid, 0), 0);

        // R9, R1: START latency and width
        s0 = n_start;
        sda_in = 1'b0;
        cyc(2);
        check(!start_pulse, "R9", "pulse before third edge", start_pulse, 0);
        cyc(1);
        check(start_pulse && busy && busy_valid, "R9", "pulse after third edge",
              pack3(busy, busy_valid, start_pulse), 7);
        cyc(1);
        check(!start_pulse, "R9", "pulse one cycle wide", start_pulse, 0);
        check(n_start == s0 + 1, "R1", "start count", n_start - s0, 1);

        // R7: SDA changes while SCL low, no event
        s0 = n_start; p0 = n_stop;
        scl_in = 1'b0; cyc(4);
        sda_in = 1'b1; cyc(4);
        scl_in = 1'b1; cyc(4);
        check(busy && n_start == s0 && n_stop == p0, "R7", "data change with SCL low",
              pack3(busy, 0, n_start - s0 + n_stop - p0), 2);

        // R6: repeated START
        sda_in = 1'b0; cyc(5);
        check(busy && n_start == s0 + 1, "R6", "repeated start", pack3(busy, 0, n_start - s0), 6);

        // R2: STOP
        p0 = n_stop;
        sda_in = 1'b1; cyc(5);
        check(!busy && busy_valid && n_stop == p0 + 1, "R2", "stop clears",
              pack3(busy, busy_valid, n_stop - p0), 5);

        // R7: SCL and SDA fall in the same cycle, no START
        s0 = n_start;
        scl_in = 1'b0; sda_in = 1'b0; cyc(5);
        check(!busy && n_start == s0, "R7", "simultaneous change", pack3(busy, 0, n_start - s0), 0);
        sda_in = 1'b1; cyc(3); scl_in = 1'b1; cyc(3);

        // R4, R3: disable while busy, bus activity ignored
        sda_in = 1'b0; cyc(5);
        run_en = 1'b0; cyc(2);
        check(!busy && !busy_valid, "R4", "cleared when disabled", pack3(busy, busy_valid, 0), 0);
        s0 = n_start; p0 = n_stop;
        sda_in = 1'b1; cyc(4); sda_in = 1'b0; cyc(4); sda_in = 1'b1; cyc(4); sda_in = 1'b0; cyc(4);
        check(n_start == s0 && n_stop == p0 && !busy, "R3", "no pulses while disabled",
              n_start - s0 + n_stop - p0, 0);

        // R5: release with lines at mid-transfer level (SCL 1, SDA 0)
        run_en = 1'b1; cyc(10);
        check(!busy && !busy_valid, "R5", "static level not inferred", pack3(busy, busy_valid, 0), 0);

        // R10: detection in the first enabled cycle is counted
        run_en = 1'b0; sda_in = 1'b1; cyc(5);
        s0 = n_start;
        sda_in = 1'b0;
        cyc(2);
        run_en = 1'b1;
        cyc(4);
        check(busy && busy_valid && n_start == s0 + 1, "R10", "event at release counted",
              pack3(busy, busy_valid, n_start - s0), 7);
        check(busy_valid, "R8", "valid after first event", busy_valid, 1);

        // R10: detection one cycle before release is lost
        run_en = 1'b0; sda_in = 1'b1; cyc(5);
        s0 = n_start;
        sda_in = 1'b0;
        cyc(3);
        run_en = 1'b1;
        cyc(4);
        check(!busy && !busy_valid && n_start == s0, "R10", "event before release lost",
              pack3(busy, busy_valid, n_start - s0), 0);

        // R8: first event after release is a STOP
        p0 = n_stop;
        sda_in = 1'b1; cyc(5);
        check(busy_valid && !busy && n_stop == p0 + 1, "R8", "stop makes flag valid",
              pack3(busy, busy_valid, n_stop - p0), 5);

        // Random walk of lines and enable against the bench model
        es = 1'b1; ed = 1'b1; eb = 1'b0; ev = 1'b1; en = 1'b1;
        for (int step = 0; step < 400; step++) begin
            int ev_kind;
            bit ns, nd;
            s0 = n_start; p0 = n_stop;
            ev_kind = 0;
            if ($urandom_range(9) == 0) begin
                en = ~en;
                run_en = en;
                if (!en) begin eb = 1'b0; ev = 1'b0; end
            end else begin
                ns = ($urandom_range(3) != 0);
                nd = $urandom_range(1);
                if (en) ev_kind = exp_event(es, ed, ns, nd);
                es = ns; ed = nd;
                scl_in = ns; sda_in = nd;
                if (ev_kind == 1) begin eb = 1'b1; ev = 1'b1; end
                if (ev_kind == 2) begin eb = 1'b0; ev = 1'b1; end
            end
            cyc(5);
            check(busy == eb && busy_valid == ev && (n_start - s0) == (ev_kind == 1)
                  && (n_stop - p0) == (ev_kind == 2), "R1/R2/R6/R7", "random step",
                  pack3(busy, busy_valid, (n_start - s0) * 2 + (n_stop - p0)),
                  pack3(eb, ev, (ev_kind == 1) ? 2 : (ev_kind == 2) ? 1 : 0));
        end

        done = 1'b1;
        finish_run();
    end

endmodule